// File: doc/BRIEF.md
# NT Deactivation Hold Controller

This block is the part of a network-termination activation sequencer that reacts to the deactivation indication carried once per superframe on the line. It keeps the current sequencer state as a 4-bit code (code n stands for state Hn). An upstream activation sequencer, outside this block, drives that code through a load strobe. While the state is one of the active-side states H6, H7, H8 or H11, the block watches the received deactivation bit. When that bit is 0 on a run of consecutive superframes, the block moves to a holding state H9. A hang-up timer, fed by a millisecond tick, moves it out of H9 to H12 after a fixed interval.

A software override input blocks the H9 path. With the override set, each superframe that carries deactivation = 0 raises a one-cycle interrupt instead. Loss of signal always drops the state to the deactivated state H1. A start-mode flag records how the last deactivation happened, so that the next activation knows whether to try a warm or a cold start. An auto-wake enable lets a detected wake-up tone power the block up from H1 into H3, with an activation-request pulse.

This block has no data stream, so it has no valid/ready interface. Every pin is a plain level or a single-cycle strobe, sampled on the rising clock edge. All outputs are registered.

Top module: `nt_deact_ctrl`

## Requirements
- R1: While rst_n is low and right after reset, state_code is 1 (H1), and dea_irq, warm_start and act_req are all 0.
- R2: A cycle with seq_ld=1 loads seq_code into state_code on the next cycle. The load is ignored while the state is H9 (code 9).
- R3: Only codes 6, 7, 8 and 11 react to a superframe with dea_bit=0. In any other state such superframes change nothing, however many arrive.
- R4: With ovr_hold=0, the DEA_RUN-th consecutive superframe (default 3) with dea_bit=0 in a reacting state moves state_code to 9 on the next cycle. A superframe with dea_bit=1 restarts the run.
- R5: The run survives a move between two reacting states. It is cleared whenever the state is outside the reacting set.
- R6: H9 is left for H12 (code 12) in the cycle after the HOLD_MS-th ms_tick (default 60) counted since entry. The count restarts from zero on every entry to H9.
- R7: With ovr_hold=1, each dea_bit=0 superframe in a reacting state gives dea_irq=1 for exactly one cycle, on the next cycle. The state never goes to H9 this way. Superframes with dea_bit=1 give no interrupt.
- R8: los=1 in any state other than H1 sets state_code to 1 on the next cycle. This takes precedence over every other transition, including the H9 timer and a load.
- R9: warm_start becomes 1 when H9 is entered through the deactivation run. On a loss-of-signal drop it becomes ovr_hold AND warm_req. That gives a cold start unless both are 1.
- R10: In H1, with auto_wake_en=1, a wake_tone pulse moves the state to H3 (code 3) with a one-cycle act_req pulse. With auto_wake_en=0 the tone is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_strb | input | 1 | One-cycle strobe per received superframe |
| dea_bit | input | 1 | Received deactivation bit, valid with sf_strb |
| los | input | 1 | Loss of signal level |
| ms_tick | input | 1 | One-cycle millisecond tick |
| ovr_hold | input | 1 | Software override: block H9 entry, interrupt instead |
| warm_req | input | 1 | Ask for a warm start after a loss-of-signal drop |
| auto_wake_en | input | 1 | Enable power-up on wake-up tone |
| wake_tone | input | 1 | Wake-up tone detected strobe |
| seq_ld | input | 1 | Load strobe from the activation sequencer |
| seq_code | input | 4 | State code to load |
| state_code | output | 4 | Current state code (n = Hn) |
| dea_irq | output | 1 | One-cycle deactivation interrupt |
| warm_start | output | 1 | 1 = next activation tries a warm start |
| act_req | output | 1 | One-cycle activation request after auto-wake |

## Verification
The bench breaks a deactivation run with a dea_bit=1 superframe. It also moves the state between two reacting states in mid-run, and through a non-reacting state in mid-run. A controller that counts total superframes, or keeps its run in the wrong case, would enter H9 one superframe early or fail to enter it at all. The hold timer is checked one tick before and at the terminal count, and again after an H9 stay cut short by loss of signal and a fresh entry; a timer that does not restart would leave H9 early. The override path is probed for single-cycle interrupts and no H9 entry. The start-mode flag is checked after each kind of deactivation, where a wrong rule would report a warm start after a cold drop.

// File: rtl/nt_deact_pkg.sv
package nt_deact_pkg;

  typedef logic [3:0] hcode_t;

  localparam hcode_t ST_H1  = 4'd1;
  localparam hcode_t ST_H3  = 4'd3;
  localparam hcode_t ST_H6  = 4'd6;
  localparam hcode_t ST_H7  = 4'd7;
  localparam hcode_t ST_H8  = 4'd8;
  localparam hcode_t ST_H9  = 4'd9;
  localparam hcode_t ST_H11 = 4'd11;
  localparam hcode_t ST_H12 = 4'd12;

  // states that react to a received dea=0
  function automatic logic reacts_to_dea(input hcode_t c);
    return (c == ST_H6) || (c == ST_H7) || (c == ST_H8) || (c == ST_H11);
  endfunction

endpackage

// File: rtl/nt_dea_run_cnt.sv
module nt_dea_run_cnt #(
  parameter int DEA_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sf_strb,
  input  logic dea_bit,
  output logic run_hit
);
  localparam int CW = $clog2(DEA_RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(DEA_RUN - 1);

  logic [CW-1:0] cnt_q;

  assign run_hit = !clr && sf_strb && !dea_bit && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (sf_strb) begin
      if (dea_bit || run_hit) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  run_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/nt_hold_timer.sv
module nt_hold_timer #(
  parameter int HOLD_MS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ms_tick,
  output logic done
);
  localparam int TW = (HOLD_MS > 1) ? $clog2(HOLD_MS) : 1;
  localparam logic [TW-1:0] LAST = TW'(HOLD_MS - 1);

  logic [TW-1:0] ms_q;

  assign done = run && ms_tick && (ms_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)      ms_q <= '0;
    else if (done)           ms_q <= '0;
    else if (ms_tick)        ms_q <= ms_q + 1'b1;
  end

  // R6
  hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= LAST);

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ms_q == '0));

endmodule

// File: rtl/nt_start_mode.sv
module nt_start_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic dea_path,
  input  logic los_path,
  input  logic ovr_hold,
  input  logic warm_req,
  output logic warm_start
);
  always_ff @(posedge clk) begin
    if (!rst_n)         warm_start <= 1'b0;
    else if (los_path)  warm_start <= ovr_hold && warm_req;
    else if (dea_path)  warm_start <= 1'b1;
  end

  // R9
  cold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los_path && !ovr_hold) |=> !warm_start);

endmodule

// File: rtl/nt_deact_ctrl.sv
module nt_deact_ctrl
  import nt_deact_pkg::*;
#(
  parameter int DEA_RUN = 3,
  parameter int HOLD_MS = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sf_strb,
  input  logic       dea_bit,
  input  logic       los,
  input  logic       ms_tick,
  input  logic       ovr_hold,
  input  logic       warm_req,
  input  logic       auto_wake_en,
  input  logic       wake_tone,
  input  logic       seq_ld,
  input  logic [3:0] seq_code,
  output logic [3:0] state_code,
  output logic       dea_irq,
  output logic       warm_start,
  output logic       act_req
);

  hcode_t st_q, st_d;
  logic   elig, run_hit, hold_done;
  logic   los_drop, wake_go, enter_h9, irq_d;

  assign elig = reacts_to_dea(st_q);

  nt_dea_run_cnt #(.DEA_RUN(DEA_RUN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!elig || ovr_hold),
    .sf_strb (sf_strb),
    .dea_bit (dea_bit),
    .run_hit (run_hit)
  );

  nt_hold_timer #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == ST_H9),
    .ms_tick (ms_tick),
    .done    (hold_done)
  );

  nt_start_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .dea_path   (enter_h9),
    .los_path   (los_drop),
    .ovr_hold   (ovr_hold),
    .warm_req   (warm_req),
    .warm_start (warm_start)
  );

  // priority: loss of signal, hold timer, wake, dea run, load
  always_comb begin
    st_d     = st_q;
    los_drop = 1'b0;
    wake_go  = 1'b0;
    enter_h9 = 1'b0;
    if (los && st_q != ST_H1) begin
      st_d     = ST_H1;
      los_drop = 1'b1;
    end else if (st_q == ST_H9) begin
      if (hold_done) st_d = ST_H12;
    end else if (st_q == ST_H1 && auto_wake_en && wake_tone) begin
      st_d    = ST_H3;
      wake_go = 1'b1;
    end else if (elig && run_hit) begin
      st_d     = ST_H9;
      enter_h9 = 1'b1;
    end else if (seq_ld) begin
      st_d = seq_code;
    end
  end

  assign irq_d = elig && sf_strb && !dea_bit && ovr_hold && !los;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_H1;
      dea_irq <= 1'b0;
      act_req <= 1'b0;
    end else begin
      st_q    <= st_d;
      dea_irq <= irq_d;
      act_req <= wake_go;
    end
  end

  assign state_code = st_q;

  // R8
  los_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los && state_code != ST_H1) |=> (state_code == ST_H1));

  // R6
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_H9) |=> (state_code == ST_H9 || state_code == ST_H12 ||
                               state_code == ST_H1));

  // R4
  h9_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_H9 && $past(state_code) != ST_H9) |->
      ($past(reacts_to_dea(state_code)) || $past(seq_ld)));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dea_irq |-> ($past(ovr_hold) && $past(sf_strb) && !$past(dea_bit)));

  // R10
  wake_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |-> (state_code == ST_H3));

  // R9
  warm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm_start) |-> (state_code == ST_H9 || state_code == ST_H1));

endmodule

// File: tb/nt_deact_ctrl_bench.sv
module nt_deact_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sf_strb = 0, dea_bit = 1, los = 0, ms_tick = 0;
  logic       ovr_hold = 0, warm_req = 0, auto_wake_en = 0, wake_tone = 0;
  logic       seq_ld = 0;
  logic [3:0] seq_code = 4'd0;
  logic [3:0] state_code;
  logic       dea_irq, warm_start, act_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;  // 50 MHz

  nt_deact_ctrl u_nt_deact_ctrl (
    .clk(clk), .rst_n(rst_n), .sf_strb(sf_strb), .dea_bit(dea_bit),
    .los(los), .ms_tick(ms_tick), .ovr_hold(ovr_hold), .warm_req(warm_req),
    .auto_wake_en(auto_wake_en), .wake_tone(wake_tone), .seq_ld(seq_ld),
    .seq_code(seq_code), .state_code(state_code), .dea_irq(dea_irq),
    .warm_start(warm_start), .act_req(act_req)
  );

  localparam logic [2:0] OP_LD = 3'd0, OP_SF = 3'd1, OP_TK = 3'd2, OP_LS = 3'd3;

  // {op, arg, ovr_hold, warm_req, exp_state, exp_irq, exp_warm}
  localparam int NV = 33;
  localparam logic [18:0] VEC [NV] = '{
    {OP_LD, 8'd6,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd0,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd0,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd1,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd0,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd0,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd0,  1'b0, 1'b0, 4'd9,  1'b0, 1'b1},
    {OP_TK, 8'd59, 1'b0, 1'b0, 4'd9,  1'b0, 1'b1},
    {OP_LD, 8'd7,  1'b0, 1'b0, 4'd9,  1'b0, 1'b1},
    {OP_TK, 8'd1,  1'b0, 1'b0, 4'd12, 1'b0, 1'b1},
    {OP_LD, 8'd11, 1'b0, 1'b0, 4'd11, 1'b0, 1'b1},
    {OP_SF, 8'd0,  1'b1, 1'b0, 4'd11, 1'b1, 1'b1},
    {OP_SF, 8'd0,  1'b1, 1'b0, 4'd11, 1'b1, 1'b1},
    {OP_SF, 8'd0,  1'b1, 1'b0, 4'd11, 1'b1, 1'b1},
    {OP_LS, 8'd0,  1'b1, 1'b0, 4'd1,  1'b0, 1'b0},
    {OP_LD, 8'd8,  1'b1, 1'b0, 4'd8,  1'b0, 1'b0},
    {OP_LS, 8'd0,  1'b1, 1'b1, 4'd1,  1'b0, 1'b1},
    {OP_LD, 8'd5,  1'b0, 1'b1, 4'd5,  1'b0, 1'b1},
    {OP_SF, 8'd0,  1'b0, 1'b1, 4'd5,  1'b0, 1'b1},
    {OP_SF, 8'd0,  1'b0, 1'b1, 4'd5,  1'b0, 1'b1},
    {OP_SF, 8'd0,  1'b0, 1'b1, 4'd5,  1'b0, 1'b1},
    {OP_LD, 8'd6,  1'b0, 1'b1, 4'd6,  1'b0, 1'b1},
    {OP_SF, 8'd0,  1'b0, 1'b1, 4'd6,  1'b0, 1'b1},
    {OP_SF, 8'd0,  1'b0, 1'b1, 4'd6,  1'b0, 1'b1},
    {OP_LD, 8'd8,  1'b0, 1'b1, 4'd8,  1'b0, 1'b1},
    {OP_SF, 8'd0,  1'b0, 1'b1, 4'd9,  1'b0, 1'b1},
    {OP_LS, 8'd0,  1'b0, 1'b1, 4'd1,  1'b0, 1'b0},
    {OP_LD, 8'd6,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd0,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd0,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_LD, 8'd5,  1'b0, 1'b0, 4'd5,  1'b0, 1'b0},
    {OP_LD, 8'd6,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0},
    {OP_SF, 8'd0,  1'b0, 1'b0, 4'd6,  1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic do_ld(input logic [3:0] c);
    @(negedge clk); seq_ld = 1; seq_code = c;
    @(negedge clk); seq_ld = 0;
  endtask

  task automatic do_sf(input logic d);
    @(negedge clk); sf_strb = 1; dea_bit = d;
    @(negedge clk); sf_strb = 0; dea_bit = 1;
  endtask

  task automatic do_tk(input int n);
    @(negedge clk); ms_tick = 1;
    repeat (n) @(negedge clk);
    ms_tick = 0;
  endtask

  task automatic do_los();
    @(negedge clk); los = 1;
    @(negedge clk); los = 0;
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      OP_LD:   return "R2";
      OP_SF:   return "R3/R4/R5/R7";
      OP_TK:   return "R6";
      default: return "R8/R9";
    endcase
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "state in reset", state_code, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "state", state_code, 1);
    chk("R1", "irq", dea_irq, 0);
    chk("R1", "warm", warm_start, 0);
    chk("R1", "act_req", act_req, 0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] arg;
      op       = VEC[i][18:16];
      arg      = VEC[i][15:8];
      ovr_hold = VEC[i][7];
      warm_req = VEC[i][6];
      case (op)
        OP_LD:   do_ld(arg[3:0]);
        OP_SF:   do_sf(arg[0]);
        OP_TK:   do_tk(int'(arg));
        default: do_los();
      endcase
      chk(tag_of(op), $sformatf("row %0d state", i), state_code, int'(VEC[i][5:2]));
      chk(tag_of(op), $sformatf("row %0d irq", i), dea_irq, int'(VEC[i][1]));
      chk(tag_of(op), $sformatf("row %0d warm", i), warm_start, int'(VEC[i][0]));
    end

    // R7: interrupt lasts one cycle; dea=1 gives none
    ovr_hold = 1;
    do_ld(4'd7);
    do_sf(1'b0);
    chk("R7", "irq pulse", dea_irq, 1);
    @(negedge clk);
    chk("R7", "irq after one cycle", dea_irq, 0);
    do_sf(1'b1);
    chk("R7", "irq on dea=1", dea_irq, 0);
    chk("R7", "no H9 under override", state_code, 7);
    ovr_hold = 0;

    // R6: timer restarts on every H9 entry
    do_sf(1'b0); do_sf(1'b0); do_sf(1'b0);
    chk("R4", "entry to H9", state_code, 9);
    do_tk(30);
    do_los();
    chk("R8", "los leaves H9", state_code, 1);
    do_ld(4'd6);
    do_sf(1'b0); do_sf(1'b0); do_sf(1'b0);
    chk("R6", "re-entry to H9", state_code, 9);
    do_tk(59);
    chk("R6", "still H9 at 59 ticks", state_code, 9);
    do_tk(1);
    chk("R6", "H12 at 60th tick", state_code, 12);

    // R8: los with a load in the same cycle
    @(negedge clk); los = 1; seq_ld = 1; seq_code = 4'd6;
    @(negedge clk); los = 0; seq_ld = 0;
    chk("R8", "los beats load", state_code, 1);

    // R10: auto wake
    @(negedge clk); wake_tone = 1;
    @(negedge clk); wake_tone = 0;
    chk("R10", "tone ignored when disabled", state_code, 1);
    chk("R10", "no act_req when disabled", act_req, 0);
    auto_wake_en = 1;
    @(negedge clk); wake_tone = 1;
    @(negedge clk); wake_tone = 0;
    chk("R10", "wake to H3", state_code, 3);
    chk("R10", "act_req pulse", act_req, 1);
    @(negedge clk);
    chk("R10", "act_req one cycle", act_req, 0);

    done_flag = 1;
    report();
  end

endmodule